// File: doc/BRIEF.md
# Dual-Channel Third-Order CIC Decimator with Byte Output

This block takes a pair of small unsigned counts per input sample, one for the in-phase (I) channel and one for the quadrature (Q) channel, and passes each through a third-order cascaded integrator-comb filter that decimates by four. Each decimated value is multiplied by a programmable gain, shifted right and re-centred so that it fits an unsigned 8-bit offset-binary byte. The two bytes of a sample leave on a single byte stream with a valid/ready handshake, I first and Q second.

The input side offers a valid strobe and returns a ready. Ready drops only when an output pair is still waiting and the next accepted sample would complete another decimation period. Both channels share one phase counter, so every output pair is built from the same four input samples. All filter state is 32 bits wide and wraps modulo 2^32; a CIC filter with this word size still produces the correct difference after the integrators wrap.

Top module: `cic_byte_decim`

## Requirements
- R1: After reset, outValid is low and inReady is high, and the first pair produced from zero inputs is 0x80, 0x80.
- R2: On every accepted input (inValid and inReady high at a clock edge) each channel updates three cascaded integrators as a1 += s, a2 += new a1, a3 += new a2, with s the zero-extended count. Inputs offered with inValid low have no effect.
- R3: Exactly one output pair is produced for every four accepted inputs, at the clock edge that accepts the fourth input.
- R4: At each output, three comb stages run in cascade starting from the new a3. Each stage outputs its input minus the input it saw at the previous output, and then stores that input.
- R5: All integrator and comb arithmetic is 32-bit and wraps modulo 2^32 with no saturation.
- R6: Each byte equals the low 8 bits of ((c * gain) >>> 10) + 128, where c is the last comb output read as a signed 32-bit value and gain is unsigned. A gain of 0 gives 0x80.
- R7: Each pair leaves as two transfers, I byte then Q byte. While outValid is high and outReady is low, outValid and outData hold.
- R8: inReady is low only while an output pair is pending and three inputs of the current period have been accepted. Data offered while inReady is low is ignored.
- R9: The I and Q channels share one decimation phase, so each pair comes from the same four accepted input samples.
- R10: Synchronous reset clears all integrator, comb, phase and output state, and discards any pending pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input count pair is valid |
| inReady | output | 1 | Block can accept an input this cycle |
| cntI | input | CNT_W | I-channel count (unsigned) |
| cntQ | input | CNT_W | Q-channel count (unsigned) |
| gain | input | GAIN_W | Unsigned output gain |
| outValid | output | 1 | outData holds a byte |
| outReady | input | 1 | Downstream takes the byte |
| outData | output | 8 | Offset-binary byte, I then Q |

## Verification
An integrator that adds the wrong term or drops a sample corrupts every later output. The error shows in the next byte pair and keeps growing, because the fault is integrated again. A comb delay that stores the wrong value spoils only the pairs that follow and shows at the next output, four accepted inputs later. A phase counter or pending flag that is wrong shows as a missing or extra byte, or as an I/Q swap. The scoreboard catches this at the first transfer after the fault, or as leftover expected bytes when the run ends.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Strobes passed from the control unit to the datapath
  typedef struct packed {
    logic accept;  // integrators advance
    logic dump;    // combs run, output bytes captured
    logic selQ;    // output mux selects the Q byte
  } cicCtrlT;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int DECIM = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output cicCtrlT ctrl
);
  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(DECIM - 1);

  logic [PH_W-1:0] phase;
  logic pending;
  logic selQ;
  logic lastPhase;
  logic accept;
  logic dump;
  logic pop;

  assign lastPhase = (phase == LAST_PH);
  assign inReady   = !(pending && lastPhase);
  assign accept    = inValid && inReady;
  assign dump      = accept && lastPhase;
  assign pop       = pending && outReady;
  assign outValid  = pending;

  assign ctrl.accept = accept;
  assign ctrl.dump   = dump;
  assign ctrl.selQ   = selQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      pending <= 1'b0;
      selQ    <= 1'b0;
    end else begin
      if (accept) phase <= lastPhase ? '0 : phase + 1'b1;
      if (dump) begin
        pending <= 1'b1;
        selQ    <= 1'b0;
      end else if (pop) begin
        if (selQ) pending <= 1'b0;
        selQ <= !selQ;
      end
    end
  end

  // R3
  dump_rate_chk: assert property (@(posedge clk) disable iff (rst)
    dump |=> (outValid && !selQ && phase == '0));

  // R8
  blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !inReady) |=> $stable(phase));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(selQ)));

  // R7
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && selQ) |=> !outValid);
endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int GAIN_W = 16,
  parameter int ACC_W  = 32,
  parameter int ORDER  = 3,
  parameter int SHIFT  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cntI,
  input  logic [CNT_W-1:0]  cntQ,
  input  logic [GAIN_W-1:0] gain,
  input  cicCtrlT           ctrl,
  output logic [7:0]        outData
);
  // Only the product bits up to SHIFT+7 reach the byte
  localparam int PW = SHIFT + 8;

  logic [CNT_W-1:0] chanCnt [2];
  logic [7:0]       chanByte [2];

  assign chanCnt[0] = cntI;
  assign chanCnt[1] = cntQ;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [ACC_W-1:0] integ [ORDER];
    logic [ACC_W-1:0] dly   [ORDER];
    logic [ACC_W-1:0] iNext [ORDER];
    logic [ACC_W-1:0] cIn   [ORDER];
    logic [ACC_W-1:0] cOut  [ORDER];
    logic [PW-1:0]    prod;
    logic [7:0]       byteNext;
    logic [7:0]       byteReg;

    always_comb begin
      for (int k = 0; k < ORDER; k++) begin
        if (k == 0) iNext[k] = integ[k] + ACC_W'(chanCnt[ch]);
        else        iNext[k] = integ[k] + iNext[k-1];
      end
      for (int k = 0; k < ORDER; k++) begin
        if (k == 0) cIn[k] = iNext[ORDER-1];
        else        cIn[k] = cOut[k-1];
        cOut[k] = cIn[k] - dly[k];
      end
      prod     = PW'(cOut[ORDER-1]) * PW'(gain);
      byteNext = 8'(prod >> SHIFT) + 8'h80;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < ORDER; k++) begin
          integ[k] <= '0;
          dly[k]   <= '0;
        end
        byteReg <= '0;
      end else begin
        if (ctrl.accept) begin
          for (int k = 0; k < ORDER; k++) integ[k] <= iNext[k];
        end
        if (ctrl.dump) begin
          for (int k = 0; k < ORDER; k++) dly[k] <= cIn[k];
          byteReg <= byteNext;
        end
      end
    end

    assign chanByte[ch] = byteReg;
  end

  assign outData = ctrl.selQ ? chanByte[1] : chanByte[0];
endmodule

// File: rtl/cic_byte_decim.sv
module cic_byte_decim
  import cic_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int GAIN_W = 16,
  parameter int ACC_W  = 32,
  parameter int DECIM  = 4,
  parameter int SHIFT  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CNT_W-1:0]  cntI,
  input  logic [CNT_W-1:0]  cntQ,
  input  logic [GAIN_W-1:0] gain,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData
);
  cicCtrlT ctrl;

  cic_ctrl #(.DECIM(DECIM)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .ctrl     (ctrl)
  );

  cic_datapath #(
    .CNT_W (CNT_W),
    .GAIN_W(GAIN_W),
    .ACC_W (ACC_W),
    .ORDER (3),
    .SHIFT (SHIFT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cntI    (cntI),
    .cntQ    (cntQ),
    .gain    (gain),
    .ctrl    (ctrl),
    .outData (outData)
  );

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> $stable(outData));
endmodule

// File: tb/cic_byte_decim_bench.sv
module cic_byte_decim_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  cntI = '0;
  logic [7:0]  cntQ = '0;
  logic [15:0] gain = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [7:0]  outData;

  always #(CLK_PERIOD/2) clk = !clk;

  cic_byte_decim u_cic_byte_decim (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .cntI(cntI), .cntQ(cntQ), .gain(gain),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  int checks = 0;
  int fails = 0;
  int readyMode = 0;   // 0 always ready, 1 random, 2 held low
  string curTag = "R2";

  logic [7:0] expQ[$];
  string      tagQ[$];

  // Reference model state, written from the requirements
  logic [31:0] mA [2][3];
  logic [31:0] mB [2][3];
  int          mPhase;

  task automatic modelReset();
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < 3; k++) begin
        mA[ch][k] = '0;
        mB[ch][k] = '0;
      end
    mPhase = 0;
  endtask

  task automatic modelAccept(input logic [7:0] si, input logic [7:0] sq);
    logic [31:0] s, c3, c2, c1;
    logic signed [63:0] p;
    for (int ch = 0; ch < 2; ch++) begin
      s = (ch == 0) ? {24'd0, si} : {24'd0, sq};
      mA[ch][0] = mA[ch][0] + s;
      mA[ch][1] = mA[ch][1] + mA[ch][0];
      mA[ch][2] = mA[ch][2] + mA[ch][1];
    end
    mPhase++;
    if (mPhase == 4) begin
      mPhase = 0;
      for (int ch = 0; ch < 2; ch++) begin
        c3 = mA[ch][2] - mB[ch][2]; mB[ch][2] = mA[ch][2];
        c2 = c3 - mB[ch][1];        mB[ch][1] = c3;
        c1 = c2 - mB[ch][0];        mB[ch][0] = c2;
        p = $signed({{32{c1[31]}}, c1});
        p = p * $signed({48'd0, gain});
        p = p >>> 10;
        expQ.push_back(p[7:0] + 8'd128);
        tagQ.push_back(curTag);
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: offers garbage while blocked (R8), real data once ready
  task automatic sendSample(input logic [7:0] si, input logic [7:0] sq);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      inValid = 1'b1;
      if (inReady) begin
        cntI = si; cntQ = sq;
        modelAccept(si, sq);
        done = 1;
      end else begin
        cntI = ~si; cntQ = 8'hA5;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;            // R2: data with inValid low is ignored
      cntI = 8'($urandom);
      cntQ = 8'($urandom);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (expQ.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  // Monitor / scoreboard and output-side driver
  logic       prevStall = 1'b0;
  logic [7:0] prevData = '0;
  always @(negedge clk) begin
    if (rst) begin
      prevStall = 1'b0;
    end else begin
      if (prevStall) begin
        // R7: held byte stays put while stalled
        check("R7 hold", {23'd0, outValid, outData}, {23'd0, 1'b1, prevData});
      end
      case (readyMode)
        0: outReady = 1'b1;
        1: outReady = ($urandom % 3) != 0;
        default: outReady = 1'b0;
      endcase
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check("R3 unexpected byte", {24'd0, outData}, 32'hFFFF_FFFF);
        end else begin
          check(tagQ.pop_front(), {24'd0, outData}, {24'd0, expQ.pop_front()});
        end
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 outValid", {31'd0, outValid}, 32'd0);
    check("R1 inReady", {31'd0, inReady}, 32'd1);

    // R1: zero input from reset gives 0x80 pair
    curTag = "R1"; gain = 16'd1024;
    repeat (4) sendSample(8'd0, 8'd0);
    idle(4); drain();

    // R2/R4: unit step on I, gain 1024 (bytes 148, 188, 192, ...)
    curTag = "R2 R4 step";
    repeat (16) sendSample(8'd1, 8'd0);
    idle(2); drain();

    // R6: step down gives negative comb output
    curTag = "R6 negative";
    repeat (12) sendSample(8'd0, 8'd1);
    idle(2); drain();

    // R3/R7/R8: random data, gaps and backpressure
    curTag = "R3 R7 R8 random"; gain = 16'd300; readyMode = 1;
    for (int i = 0; i < 80; i++) begin
      sendSample(8'($urandom % 33), 8'($urandom % 33));
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    idle(2); drain(); readyMode = 0;

    // R5: large counts push integrators past 2^32
    curTag = "R5 wrap"; gain = 16'd5;
    for (int i = 0; i < 800; i++) sendSample(8'd255, 8'd200);
    idle(2); drain();

    // R10: reset with a pair pending
    curTag = "R10";
    readyMode = 2;
    repeat (4) sendSample(8'd7, 8'd9);
    idle(3);
    @(posedge clk); #1 rst = 1'b1;
    expQ.delete(); tagQ.delete(); modelReset();
    @(posedge clk); #1 rst = 1'b0;
    readyMode = 0;
    @(negedge clk);
    check("R10 outValid", {31'd0, outValid}, 32'd0);
    check("R10 inReady", {31'd0, inReady}, 32'd1);

    // R9/R10: distinct I and Q from cleared state, gain 1024 -> 168, 188 first
    curTag = "R9 R10 aligned"; gain = 16'd1024;
    repeat (8) sendSample(8'd2, 8'd3);
    idle(2); drain();

    // R6: gain 0 yields 0x80
    curTag = "R6 gain0"; gain = 16'd0;
    repeat (8) sendSample(8'd31, 8'd17);
    idle(2); drain();

    // R3: every expected byte was delivered
    check("R3 leftover", expQ.size(), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule